// File: doc/BRIEF.md
# Switch Port Admission and Learning Gate

This block sits between the receive side of each switch port and the switch fabric. For every frame it decides whether the frame is admitted, whether its source address may be learned, and whether the port may transmit. Each port's decisions come from one control byte per port, and a single global control byte sets the frame-length ceiling for all ports.

Each port has a frame-start strobe, a frame-end strobe and a byte count that is valid with the end strobe. The block takes a copy of the port control bits and of the length ceiling when a frame starts. It judges the frame against that copy when the frame ends, so register writes made while a frame is in flight do not affect that frame. The verdict appears one clock after the end strobe as a one-cycle pulse: either admit or drop, together with a learn pulse. Transmit enable is a level output that changes only between frames.

Top module: `port_admit_gate`

## Requirements
- R1: While reset is low at a clock edge, every admit, drop, learn and transmit-enable output is 0 after that edge, whatever the control inputs are.
- R2: Port p's control byte is port_cfg[8p+7:8p]. Bit 2 is transmit enable, bit 1 is receive enable and bit 0 is learning disable. While the port has no open frame, tx_en[p] takes bit 2 one clock after it is applied.
- R3: For a frame-end strobe that closes an open frame, exactly one of rx_accept[p] or rx_drop[p] pulses high for one cycle, in the cycle after the strobe.
- R4: A frame whose snapshotted receive enable is 0 is dropped, whatever its length.
- R5: learn_en[p] pulses together with the verdict exactly when the snapshotted learning-disable bit is 0. This holds whether the frame is admitted or dropped.
- R6: The ceiling comes from glob_cfg bits 2 (huge) and 1 (override). If bit 2 is set the ceiling is 1916 bytes. If only bit 1 is set it is 1536. If neither is set it is 1522. A frame whose count equals the ceiling is admitted, and a frame one byte longer is dropped. One global setting applies to all ports.
- R7: A frame shorter than 64 bytes is dropped, and a 64-byte frame with receive enabled is admitted.
- R8: The control bits and the ceiling are sampled at the frame-start strobe. Changes made after the start do not affect the verdict of that frame. tx_en[p] holds its value while the frame is open.
- R9: A frame-end strobe on a port with no open frame gives no pulse. A start and an end in the same cycle form a one-cycle frame, judged by the settings present in that cycle.
- R10: Ports are independent. Frames on different ports may overlap or end in the same cycle, and each port's pulses reflect only its own frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | NUM_PORTS | Per-port frame start strobe |
| frame_end | input | NUM_PORTS | Per-port frame end strobe |
| frame_bytes | input | NUM_PORTS*CNT_W | Per-port byte count, valid with frame_end |
| port_cfg | input | NUM_PORTS*8 | Per-port control bytes |
| glob_cfg | input | 8 | Global control byte |
| rx_accept | output | NUM_PORTS | Admit pulse |
| rx_drop | output | NUM_PORTS | Drop pulse |
| learn_en | output | NUM_PORTS | Source-learning permit pulse |
| tx_en | output | NUM_PORTS | Transmit enable level |

## Verification
The hardest case to reach is a frame whose settings change between its start and its end. The verdict must then follow the snapshot taken at the start, not the live registers. Each stimulated frame draws a new random port control byte and a new global byte in the cycle after its start strobe, then holds the frame open for a random gap. The expected values are computed only from the start-time values. Length counts are drawn so that they cluster on each ceiling, one byte either side of it, and on the 64-byte floor.

// File: rtl/admit_pkg.sv
// Shared types for the port admission gate.
// Assumes an 8-bit control byte with the fields at fixed low bit positions.
package admit_pkg;
    typedef struct packed {
        logic tx_on;
        logic rx_on;
        logic learn_off;
    } port_ctl_t;

    // Extract the three decision bits from a port control byte
    function automatic port_ctl_t decode_ctl(input logic [7:0] b);
        port_ctl_t c;
        c.tx_on     = b[2];
        c.rx_on     = b[1];
        c.learn_off = b[0];
        return c;
    endfunction
endpackage

// File: rtl/admit_len_sel.sv
// Length ceiling selector: turns the global huge/override bits into a byte limit.
// Assumes huge has priority over override; purely combinational.
module admit_len_sel #(
    parameter int CNT_W    = 11,
    parameter int LIM_STD  = 1522,
    parameter int LIM_OVR  = 1536,
    parameter int LIM_HUGE = 1916
) (
    input  logic [7:0]       glob_cfg,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] L_STD  = CNT_W'(LIM_STD);
    localparam logic [CNT_W-1:0] L_OVR  = CNT_W'(LIM_OVR);
    localparam logic [CNT_W-1:0] L_HUGE = CNT_W'(LIM_HUGE);

    // Pick the ceiling by priority: huge, then override, then standard
    always_comb begin
        if (glob_cfg[2])      limit = L_HUGE;
        else if (glob_cfg[1]) limit = L_OVR;
        else                  limit = L_STD;
    end

    // R6: the ceiling is always one of the three legal values
    always_comb begin
        p_limit_legal_r6: assert (limit == L_STD || limit == L_OVR || limit == L_HUGE)
            else $error("limit out of set");
    end
endmodule

// File: rtl/admit_lane.sv
// One port lane: snapshots control and ceiling at frame start, gives the verdict at frame end.
// Assumes frame_bytes is valid only together with frame_end; outputs are registered.
module admit_lane
    import admit_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic [CNT_W-1:0] bytes,
    input  logic [7:0]       ctl_byte,
    input  logic [CNT_W-1:0] cur_limit,
    output logic             accept,
    output logic             drop,
    output logic             learn,
    output logic             tx_on
);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_LEN);

    port_ctl_t        cur_ctl, snap_ctl, use_ctl;
    logic [CNT_W-1:0] snap_lim, use_lim;
    logic             busy_q, end_valid, len_ok;

    assign cur_ctl = decode_ctl(ctl_byte);

    // Select live settings for a one-cycle frame, otherwise the snapshot
    always_comb begin
        use_ctl   = sof ? cur_ctl : snap_ctl;
        use_lim   = sof ? cur_limit : snap_lim;
        end_valid = eof && (busy_q || sof);
        len_ok    = (bytes >= MIN_L) && (bytes <= use_lim);
    end

    // Track the open frame and capture settings at its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            snap_ctl <= '0;
            snap_lim <= '0;
        end else begin
            if (sof) begin
                busy_q   <= !eof;
                snap_ctl <= cur_ctl;
                snap_lim <= cur_limit;
            end else if (eof) begin
                busy_q   <= 1'b0;
            end
        end
    end

    // Produce the end-of-frame verdict pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            drop   <= 1'b0;
            learn  <= 1'b0;
        end else begin
            accept <= end_valid && use_ctl.rx_on && len_ok;
            drop   <= end_valid && !(use_ctl.rx_on && len_ok);
            learn  <= end_valid && !use_ctl.learn_off;
        end
    end

    // Reload transmit enable only between frames or at a frame start
    always_ff @(posedge clk) begin
        if (!rst_n)               tx_on <= 1'b0;
        else if (!busy_q || sof)  tx_on <= cur_ctl.tx_on;
    end

    // R3: admit and drop never pulse together
    p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && drop));
    // R9: any pulse follows a frame-end strobe
    p_pulse_needs_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || drop || learn) |-> $past(eof));
    // R4: a snapshotted receive-disable always ends in a drop
    p_rx_off_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && busy_q && !sof && !snap_ctl.rx_on) |=> drop);
    // R8: transmit enable is frozen inside an open frame
    p_tx_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !sof && !eof) |=> $stable(tx_on));
endmodule

// File: rtl/port_admit_gate.sv
// Switch port admission and learning gate: one shared length selector, one lane per port.
// Assumes a single global control byte for all ports and per-port bytes packed by port index.
module port_admit_gate #(
    parameter int NUM_PORTS = 5,
    parameter int CNT_W     = 11,
    parameter int MIN_LEN   = 64,
    parameter int LIM_STD   = 1522,
    parameter int LIM_OVR   = 1536,
    parameter int LIM_HUGE  = 1916
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       frame_start,
    input  logic [NUM_PORTS-1:0]       frame_end,
    input  logic [NUM_PORTS*CNT_W-1:0] frame_bytes,
    input  logic [NUM_PORTS*8-1:0]     port_cfg,
    input  logic [7:0]                 glob_cfg,
    output logic [NUM_PORTS-1:0]       rx_accept,
    output logic [NUM_PORTS-1:0]       rx_drop,
    output logic [NUM_PORTS-1:0]       learn_en,
    output logic [NUM_PORTS-1:0]       tx_en
);
    logic [CNT_W-1:0] cur_limit;

    admit_len_sel #(
        .CNT_W(CNT_W), .LIM_STD(LIM_STD), .LIM_OVR(LIM_OVR), .LIM_HUGE(LIM_HUGE)
    ) u_len (
        .glob_cfg (glob_cfg),
        .limit    (cur_limit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        admit_lane #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sof       (frame_start[p]),
            .eof       (frame_end[p]),
            .bytes     (frame_bytes[p*CNT_W +: CNT_W]),
            .ctl_byte  (port_cfg[p*8 +: 8]),
            .cur_limit (cur_limit),
            .accept    (rx_accept[p]),
            .drop      (rx_drop[p]),
            .learn     (learn_en[p]),
            .tx_on     (tx_en[p])
        );
    end

    // R1: all outputs are cleared in the cycle after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_accept == '0 && rx_drop == '0 && learn_en == '0 && tx_en == '0));
endmodule

// File: tb/tb_port_admit_gate.sv
module tb_port_admit_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int CW = 11;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NP-1:0]   frame_start, frame_end;
    logic [NP*CW-1:0] frame_bytes;
    logic [NP*8-1:0] port_cfg;
    logic [7:0]      glob_cfg;
    logic [NP-1:0]   rx_accept, rx_drop, learn_en, tx_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_admit_gate #(.NUM_PORTS(NP), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .frame_bytes(frame_bytes), .port_cfg(port_cfg), .glob_cfg(glob_cfg),
        .rx_accept(rx_accept), .rx_drop(rx_drop), .learn_en(learn_en), .tx_en(tx_en)
    );

    function automatic int exp_limit(input logic [7:0] g);
        if (g[2]) return 1916;
        if (g[1]) return 1536;
        return 1522;
    endfunction

    function automatic bit exp_ok(input logic [7:0] c, input logic [7:0] g, input int n);
        return c[1] && n >= 64 && n <= exp_limit(g);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check port p's verdict and that other ports are quiet
    task automatic chk_verdict(input string req, input int p, input logic [7:0] c,
                               input logic [7:0] g, input int n);
        bit ok = exp_ok(c, g, n);
        chk({req, " accept"}, int'(rx_accept[p]), int'(ok));
        chk({req, " drop"},   int'(rx_drop[p]),   int'(!ok));
        chk({req, " learn R5"}, int'(learn_en[p]), int'(!c[0]));
        for (int q = 0; q < NP; q++)
            if (q != p) chk("R10 other port quiet", int'(rx_accept[q] | rx_drop[q] | learn_en[q]), 0);
    endtask

    function automatic int pick_len();
        int k = int'($urandom_range(0, 9));
        case (k)
            0: return 63;  1: return 64;  2: return 1522; 3: return 1523;
            4: return 1536; 5: return 1537; 6: return 1916; 7: return 1917;
            8: return int'($urandom_range(0, 63));
            default: return int'($urandom_range(64, 2047));
        endcase
    endfunction

    // Frame on port p with settings changed after the start
    task automatic run_frame(input int p, input logic [7:0] c0, input logic [7:0] g0,
                             input logic [7:0] c1, input logic [7:0] g1, input int n, input int gap);
        @(negedge clk);
        port_cfg[p*8 +: 8] = c0; glob_cfg = g0; frame_start[p] = 1'b1;
        @(posedge clk); #1;
        chk("R8 tx at start", int'(tx_en[p]), int'(c0[2]));
        @(negedge clk);
        frame_start[p] = 1'b0; port_cfg[p*8 +: 8] = c1; glob_cfg = g1;
        repeat (gap) @(negedge clk);
        frame_end[p] = 1'b1; frame_bytes[p*CW +: CW] = CW'(n);
        @(posedge clk); #1;
        chk_verdict("R3 R4 R6 R7 R8", p, c0, g0, n);
        chk("R8 tx held", int'(tx_en[p]), int'(c0[2]));
        @(negedge clk);
        frame_end[p] = 1'b0;
        @(posedge clk); #1;
        chk("R3 single pulse", int'(rx_accept[p] | rx_drop[p]), 0);
        chk("R2 tx reload", int'(tx_en[p]), int'(c1[2]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; frame_start = '0; frame_end = '0; frame_bytes = '0;
        port_cfg = '1; glob_cfg = '1;
        repeat (3) @(posedge clk); #1;
        chk("R1 reset accept", int'(rx_accept), 0);
        chk("R1 reset drop", int'(rx_drop), 0);
        chk("R1 reset learn", int'(learn_en), 0);
        chk("R1 reset tx", int'(tx_en), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R2 tx follows bit2", int'(tx_en), 31);
        @(negedge clk); port_cfg = {NP{8'b0000_0011}};
        @(posedge clk); #1;
        chk("R2 tx clear", int'(tx_en), 0);

        // R6 / R7 boundary frames
        run_frame(0, 8'h06, 8'h00, 8'h06, 8'h00, 1522, 2);
        run_frame(0, 8'h06, 8'h00, 8'h06, 8'h04, 1523, 2);
        run_frame(1, 8'h06, 8'h02, 8'h06, 8'h00, 1536, 1);
        run_frame(1, 8'h06, 8'h02, 8'h06, 8'h04, 1537, 1);
        run_frame(2, 8'h06, 8'h06, 8'h06, 8'h00, 1916, 3);
        run_frame(2, 8'h06, 8'h04, 8'h06, 8'h00, 1917, 3);
        run_frame(3, 8'h06, 8'h00, 8'h06, 8'h00, 64, 0);
        run_frame(3, 8'h06, 8'h00, 8'h06, 8'h00, 63, 0);
        // R4 rx off, R5 learn while dropped
        run_frame(4, 8'h04, 8'h00, 8'h07, 8'h00, 200, 2);
        // R8 rx enabled later does not help
        run_frame(4, 8'h01, 8'h00, 8'h06, 8'h06, 1000, 4);

        // R9 stray end
        @(negedge clk); frame_end[2] = 1'b1; frame_bytes[2*CW +: CW] = CW'(100); port_cfg[23:16] = 8'h06;
        @(posedge clk); #1;
        chk("R9 stray end", int'(rx_accept[2] | rx_drop[2] | learn_en[2]), 0);
        @(negedge clk); frame_end[2] = 1'b0;

        // R9 one-cycle frame with live settings
        @(negedge clk);
        port_cfg[15:8] = 8'h02; glob_cfg = 8'h02; frame_start[1] = 1'b1; frame_end[1] = 1'b1;
        frame_bytes[1*CW +: CW] = CW'(1530);
        @(posedge clk); #1;
        chk_verdict("R9 one-cycle", 1, 8'h02, 8'h02, 1530);
        @(negedge clk); frame_start[1] = 1'b0; frame_end[1] = 1'b0;

        // R10 overlapping frames ending together
        @(negedge clk);
        port_cfg[7:0] = 8'h06; port_cfg[31:24] = 8'h05; glob_cfg = 8'h00; frame_start = 5'b01001;
        @(negedge clk); frame_start = '0; port_cfg = '0; glob_cfg = 8'h04;
        @(negedge clk);
        frame_end = 5'b01001; frame_bytes[0 +: CW] = CW'(1500); frame_bytes[3*CW +: CW] = CW'(1500);
        @(posedge clk); #1;
        chk("R10 port0 accept", int'(rx_accept[0]), 1);
        chk("R10 port0 learn", int'(learn_en[0]), 1);
        chk("R10 port3 drop", int'(rx_drop[3]), 1);
        chk("R10 port3 learn", int'(learn_en[3]), 0);
        chk("R10 others quiet", int'((rx_accept | rx_drop) & 5'b10110), 0);
        @(negedge clk); frame_end = '0;

        // Random frames
        for (int i = 0; i < 400; i++) begin
            run_frame(int'($urandom_range(0, NP-1)), 8'($urandom), 8'($urandom),
                      8'($urandom), 8'($urandom), pick_len(), int'($urandom_range(0, 5)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule